// File: doc/BRIEF.md
# Configuration Source Priority Arbiter

This block decides which of four configuration sources owns a device's configuration logic at any moment. The sources are a program pin, a boundary-scan controller, a host-bus (PCI) loader and the strapped mode-pin engine. Each raises a level request. The arbiter registers a fixed-priority choice every clock. A higher source takes over from a lower one even while the lower one is part way through a load, and the source that lost its grant gets a one-cycle abort pulse.

After a host-bus load finishes, the arbiter enters a sticky locked state. In that state only boundary scan can obtain a grant. The locked state ends only when the program pin has been released after being asserted and the device reset is then asserted. The configuration engines themselves are outside this block. It only grants ownership and signals preemption.

Top module: `cfg_src_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `grant_o` equals 5'b00001 (no owner), `abort_o` is zero and the arbiter is not locked.
- R2: `grant_o` always has exactly one bit set. Bit 0 means no owner, bit 1 strap, bit 2 bus, bit 3 scan and bit 4 program.
- R3: Priority runs program > scan > bus > strap. The grant reflects the requests sampled at a clock edge right after that edge, so it follows a new request one clock later.
- R4: A bus request is granted whatever the strap request is doing, and it takes the grant from an active strap owner.
- R5: A scan request takes the grant from an active bus owner.
- R6: A program request takes the grant from scan, bus and strap owners when unlocked.
- R7: `abort_o` bit 0 (strap), bit 1 (bus), bit 2 (scan) or bit 3 (program) pulses for exactly the cycle in which that source's grant is first lost to a higher-priority source. When an owner loses the grant because its own request dropped, no abort bit is set.
- R8: The arbiter locks at the clock edge where `bus_done` is high while the bus holds the grant.
- R9: Once locked, from the next grant update on, program, bus and strap requests are ignored: the grant is scan when `scan_req` is high, otherwise none.
- R10: Asserting `dev_reset` alone does not unlock. The arbiter unlocks only when `dev_reset` is sampled high after a falling edge of `prog_req` has been sampled while locked.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the arbiter |
| prog_req | input | 1 | Program pin request (level) |
| scan_req | input | 1 | Boundary-scan configuration request |
| bus_req | input | 1 | Host-bus configuration request |
| strap_req | input | 1 | Strapped mode-pin configuration request |
| bus_done | input | 1 | Host-bus load completed (pulse) |
| dev_reset | input | 1 | Device reset pin asserted |
| grant_o | output | 5 | One-hot owner: {prog, scan, bus, strap, none} |
| abort_o | output | 4 | Preemption pulse per source: {prog, scan, bus, strap} |

## Verification
The hardest state to reach is the unlock path. It needs a completed bus load, a program-pin release seen while locked, and then a device reset, in that order. The same steps in the wrong order must leave the arbiter locked. The stimulus walks this sequence deliberately: it first applies a lone reset, then the toggle, then the reset. It then runs a long pseudo-random phase in which completion, toggle and reset events overlap with every request pattern. A behavioural model checks every cycle of that phase.

// File: rtl/cfgarb_pkg.sv
package cfgarb_pkg;
    localparam int NSRC = 4;                 // strap, bus, scan, prog
    localparam int GW   = NSRC + 1;          // grant width including "none"
    localparam int OWB  = $clog2(NSRC + 1);

    typedef enum logic [OWB-1:0] {
        OWN_NONE  = 3'd0,
        OWN_STRAP = 3'd1,
        OWN_BUS   = 3'd2,
        OWN_SCAN  = 3'd3,
        OWN_PROG  = 3'd4
    } owner_e;

    // request vector index = owner code - 1
    localparam int IDX_STRAP = 0;
    localparam int IDX_BUS   = 1;
    localparam int IDX_SCAN  = 2;
    localparam int IDX_PROG  = 3;

    typedef struct packed {
        logic locked;
        logic toggle_seen;
        logic prog_q;
    } lock_st_t;

    function automatic logic [GW-1:0] owner_onehot(input owner_e o);
        logic [GW-1:0] v;
        v = '0;
        v[o] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/cfgarb_lock.sv
module cfgarb_lock
    import cfgarb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic prog_req,
    input  logic bus_done,
    input  logic bus_owned,
    input  logic dev_reset,
    output logic locked
);
    lock_st_t st_q, st_d;
    logic     prog_fall;

    assign prog_fall = st_q.prog_q && !prog_req;

    always_comb begin
        st_d        = st_q;
        st_d.prog_q = prog_req;
        if (bus_done && bus_owned) begin
            st_d.locked      = 1'b1;
            st_d.toggle_seen = 1'b0;
        end else if (st_q.locked) begin
            if (dev_reset && st_q.toggle_seen) begin
                st_d.locked      = 1'b0;
                st_d.toggle_seen = 1'b0;
            end else if (prog_fall) begin
                st_d.toggle_seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign locked = st_q.locked;

    // R8: a completed bus load locks on the next cycle
    a_r8_lock_sets: assert property (@(posedge clk) disable iff (rst)
        (bus_done && bus_owned) |=> locked);
    // R10: without a reset request the lock persists
    a_r10_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (locked && !dev_reset) |=> locked);
endmodule

// File: rtl/cfgarb_pick.sv
module cfgarb_pick
    import cfgarb_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] enable,
    output owner_e       winner
);
    logic [N-1:0] live;
    assign live = req & enable;

    // ascending scan: last (highest index) live source wins
    always_comb begin
        winner = OWN_NONE;
        for (int i = 0; i < N; i++) begin
            if (live[i]) winner = owner_e'(i + 1);
        end
    end
endmodule

// File: rtl/cfg_src_arbiter.sv
module cfg_src_arbiter
    import cfgarb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          prog_req,
    input  logic          scan_req,
    input  logic          bus_req,
    input  logic          strap_req,
    input  logic          bus_done,
    input  logic          dev_reset,
    output logic [GW-1:0] grant_o,
    output logic [NSRC-1:0] abort_o
);
    logic [NSRC-1:0] req_v, en_v, abort_d;
    owner_e          owner_q, nxt;
    logic            locked;

    assign req_v[IDX_STRAP] = strap_req;
    assign req_v[IDX_BUS]   = bus_req;
    assign req_v[IDX_SCAN]  = scan_req;
    assign req_v[IDX_PROG]  = prog_req;

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            if (s == IDX_SCAN) begin : g_free
                assign en_v[s] = 1'b1;
            end else begin : g_lockable
                assign en_v[s] = !locked;
            end
            assign abort_d[s] = (owner_q == owner_e'(s + 1)) &&
                                (nxt > owner_e'(s + 1));
            // R7: an abort never coincides with the grant it reports as lost
            a_r7_abort_lost: assert property (@(posedge clk) disable iff (rst)
                abort_o[s] |-> !grant_o[s+1]);
        end
    endgenerate

    cfgarb_pick #(.N(NSRC)) u_pick (
        .req    (req_v),
        .enable (en_v),
        .winner (nxt)
    );

    cfgarb_lock u_lock (
        .clk       (clk),
        .rst       (rst),
        .prog_req  (prog_req),
        .bus_done  (bus_done),
        .bus_owned (owner_q == OWN_BUS),
        .dev_reset (dev_reset),
        .locked    (locked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_NONE;
            abort_o <= '0;
        end else begin
            owner_q <= nxt;
            abort_o <= abort_d;
        end
    end

    assign grant_o = owner_onehot(owner_q);

    // R2: exactly one owner code
    a_r2_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(grant_o) == 1);
    // R7: at most one source aborted at a time
    a_r7_abort_single: assert property (@(posedge clk) disable iff (rst)
        $onehot0(abort_o));
    // R3/R6: an unlocked program request owns the next cycle
    a_r3_prog_first: assert property (@(posedge clk) disable iff (rst)
        (prog_req && !locked) |=> grant_o[4]);
    // R9: a settled lock leaves only scan or none
    a_r9_locked_scan_only: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked)) |-> !(grant_o[1] || grant_o[2] || grant_o[4]));
endmodule

// File: tb/sim_cfg_src_arbiter.sv
`timescale 1ns/1ps
module sim_cfg_src_arbiter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prog_req = 0, scan_req = 0, bus_req = 0, strap_req = 0;
    logic bus_done = 0, dev_reset = 0;
    logic [4:0] grant_o;
    logic [3:0] abort_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int m_owner = 0;      // 0 none,1 strap,2 bus,3 scan,4 prog
    int m_abort = 0;
    bit m_lock = 0, m_seen = 0, m_progq = 0;

    always #2.5 clk = ~clk;

    cfg_src_arbiter u0 (
        .clk(clk), .rst(rst), .prog_req(prog_req), .scan_req(scan_req),
        .bus_req(bus_req), .strap_req(strap_req), .bus_done(bus_done),
        .dev_reset(dev_reset), .grant_o(grant_o), .abort_o(abort_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int best, ab;
        bit fall;
        if (rst) begin
            m_owner = 0; m_abort = 0; m_lock = 0; m_seen = 0; m_progq = 0;
            return;
        end
        best = 0;
        if (prog_req && !m_lock)       best = 4;
        else if (scan_req)             best = 3;
        else if (bus_req && !m_lock)   best = 2;
        else if (strap_req && !m_lock) best = 1;
        ab = (m_owner != 0 && best > m_owner) ? (1 << (m_owner - 1)) : 0;
        fall = m_progq && !prog_req;
        if (bus_done && m_owner == 2) begin
            m_lock = 1; m_seen = 0;
        end else if (m_lock) begin
            if (dev_reset && m_seen) begin m_lock = 0; m_seen = 0; end
            else if (fall) m_seen = 1;
        end
        m_progq = prog_req;
        m_owner = best;
        m_abort = ab;
    endtask

    task automatic cyc(input string tag, input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            chk({tag, " grant"}, grant_o, 1 << m_owner);
            chk({tag, " abort"}, abort_o, m_abort);
        end
    endtask

    task automatic drv(input bit p, input bit sc, input bit b, input bit st,
                       input bit bd, input bit dr);
        prog_req = p; scan_req = sc; bus_req = b; strap_req = st;
        bus_done = bd; dev_reset = dr;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc("R1 in reset", 2);
        chk("R1 reset grant none", grant_o, 5'b00001);
        chk("R1 reset abort zero", abort_o, 0);
        rst = 0;
        cyc("R1 after reset", 1);
        chk("R1 idle grant", grant_o, 5'b00001);

        drv(0,0,0,1,0,0); cyc("R3 strap alone", 2);
        chk("R3 strap owns", grant_o, 5'b00010);
        drv(0,0,1,1,0,0); cyc("R4 bus preempts strap", 1);
        chk("R4 bus owns", grant_o, 5'b00100);
        chk("R7 strap abort", abort_o, 4'b0001);
        cyc("R7 pulse one cycle", 1);
        chk("R7 abort cleared", abort_o, 0);
        drv(0,1,1,1,0,0); cyc("R5 scan preempts bus", 1);
        chk("R5 scan owns", grant_o, 5'b01000);
        chk("R5 bus abort", abort_o, 4'b0010);
        drv(1,1,1,1,0,0); cyc("R6 prog preempts scan", 1);
        chk("R6 prog owns", grant_o, 5'b10000);
        chk("R6 scan abort", abort_o, 4'b0100);
        drv(0,1,1,1,0,0); cyc("R7 release no abort", 1);
        chk("R7 no abort on release", abort_o, 0);
        chk("R3 scan returns", grant_o, 5'b01000);
        drv(0,0,1,0,0,0); cyc("R3 bus", 2);
        drv(1,0,1,0,0,0); cyc("R6 prog over bus", 1);
        chk("R6 bus aborted", abort_o, 4'b0010);

        // lock sequence
        drv(0,0,1,1,0,0); cyc("R4 bus with strap", 2);
        chk("R4 bus over strap", grant_o, 5'b00100);
        drv(0,0,1,1,1,0); cyc("R8 done", 1);
        chk("R8 grant at done edge", grant_o, 5'b00100);
        drv(1,0,1,1,0,0); cyc("R9 locked", 3);
        chk("R9 prog ignored", grant_o, 5'b00001);
        drv(1,1,1,1,0,0); cyc("R9 scan allowed", 2);
        chk("R9 scan owns locked", grant_o, 5'b01000);
        drv(1,0,1,1,0,1); cyc("R10 reset alone", 2);
        drv(1,0,1,1,0,0); cyc("R10 still locked", 2);
        chk("R10 lock kept", grant_o, 5'b00001);
        drv(0,0,1,1,0,0); cyc("R10 toggle", 2);
        chk("R10 locked after toggle", grant_o, 5'b00001);
        drv(0,0,1,1,0,1); cyc("R10 reset after toggle", 1);
        drv(0,0,0,1,0,0); cyc("R10 unlocked", 2);
        chk("R10 strap owns again", grant_o, 5'b00010);

        // pseudo-random phase against the model
        for (int k = 0; k < 4000; k++) begin
            drv($urandom_range(0,3) == 0, $urandom_range(0,3) == 0,
                $urandom_range(0,1) == 1, $urandom_range(0,1) == 1,
                $urandom_range(0,7) == 0, $urandom_range(0,11) == 0);
            cyc("R2 random", 1);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule